// File: doc/BRIEF.md
# Data-Space Effective Address Generator

This block sits beside the decoder of a small 8-bit load/store core with 32 general registers. For each load or store it takes the decoded addressing mode, the register index, the 6-bit I/O field, the second instruction word, a pointer-pair selector, a displacement, and the six register bytes that form the three 16-bit pointer pairs. From these it computes the data-space effective address.

The block also reports two further results. It gives the execution cost in clock cycles. For the auto-indexing modes it gives a pointer write-back (new value, pair index and enable), which the register file applies afterwards.

The data space is laid out as follows. The general registers sit at 0x00 to 0x1F. The 64 directly reachable I/O registers follow at 0x20 to 0x5F. The extended I/O range runs from 0x60 to 0xFF. All results are registered, so they appear one clock after the request is presented.

Top module: `dag_top`

## Requirements
- R1: While reset (rst_n low) is held and after it is released with no request, every output is zero.
- R2: The results for a request presented with `req_valid` high appear on the outputs after exactly one rising clock edge, together with `res_valid`. A cycle without a request produces all-zero outputs.
- R3: Mode code 1 (register direct) gives `ea` equal to the zero-extended 5-bit register index (0 to 31) and a cost of 2 cycles.
- R4: Mode code 2 (I/O direct) gives `ea` = 6-bit I/O address + 0x20, which lies in the range 0x20 to 0x5F, at a cost of 1 cycle.
- R5: Mode code 3 (data direct) gives `ea` equal to the low 16 bits of the second instruction word, at a cost of 2 cycles.
- R6: Mode code 4 (indirect) gives `ea` equal to the selected pointer, at a cost of 2 cycles. Selector 0 picks X = {R27,R26}, selector 1 picks Y = {R29,R28} and selector 2 picks Z = {R31,R30}. In `ptr_regs`, pair k occupies bits [16k+15:16k], with the higher-numbered register in the upper byte.
- R7: Mode code 5 (displacement) gives `ea` = pointer + zero-extended 6-bit displacement, modulo 2^16, at a cost of 2 cycles. This mode accepts only Y or Z.
- R8: Mode code 6 (post-increment) gives `ea` equal to the pointer, and writes back pointer+1 (modulo 2^16) with `wb_ptr` set to the selector. The cost is 2 cycles.
- R9: Mode code 7 (pre-decrement) gives `ea` equal to pointer-1 (modulo 2^16), and writes back that same value with `wb_ptr` set to the selector. The cost is 2 cycles.
- R10: `wb_en` is high only for accepted post-increment and pre-decrement requests. In all other modes `wb_en`, `wb_ptr` and `wb_val` are zero.
- R11: Mode code 0 (immediate) uses no address. It gives `ea` = 0 and a cost of 1 cycle.
- R12: A pointer mode given selector 3, or a displacement request on X, raises `mode_err`. The same result has `ea`, the write-back outputs and `cycles` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code (0 to 7) |
| reg_idx | input | 5 | Register index for register direct |
| io_addr | input | 6 | I/O direct address |
| word2 | input | 16 | Second instruction word |
| ptr_sel | input | 2 | Pointer pair selector: 0 X, 1 Y, 2 Z |
| disp | input | 6 | Unsigned displacement |
| ptr_regs | input | 48 | Bytes R26 to R31, R26 in the lowest byte |
| res_valid | output | 1 | Registered result valid |
| ea | output | 16 | Effective address |
| cycles | output | 2 | Execution cost in clocks |
| wb_en | output | 1 | Pointer write-back enable |
| wb_ptr | output | 2 | Pointer pair to update |
| wb_val | output | 16 | New pointer value |
| mode_err | output | 1 | Illegal pointer/mode combination |

## Verification
The bench uses the default parameters: a 16-bit address, a 6-bit I/O field, a 6-bit displacement and a 0x20 I/O base. These defaults put the wrap points within reach. Post-increment from 0xFFFF, pre-decrement from 0x0000 and a maximum displacement added to a base near 0xFFFF all cross the 16-bit boundary. The top and bottom of the I/O window are also covered. Each cycle's outputs are compared against a behavioural integer model, through both directed corner vectors and a pseudo-random stream of mixed modes.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [2:0] {
    AM_IMM  = 3'd0,
    AM_REG  = 3'd1,
    AM_IO   = 3'd2,
    AM_DIR  = 3'd3,
    AM_IND  = 3'd4,
    AM_DISP = 3'd5,
    AM_PINC = 3'd6,
    AM_PDEC = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    PP_X    = 2'd0,
    PP_Y    = 2'd1,
    PP_Z    = 2'd2,
    PP_NONE = 2'd3
  } ppair_e;
endpackage

// File: rtl/dag_ptr_mux.sv
module dag_ptr_mux #(
  parameter int AW    = 16,
  parameter int NPAIR = 3
) (
  input  logic [NPAIR*AW-1:0] regs_i,
  input  logic [1:0]          sel_i,
  output logic [AW-1:0]       ptr_o,
  output logic                ok_o
);
  logic [AW-1:0] pair [NPAIR];

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    assign pair[k] = regs_i[k*AW +: AW];
  end

  always_comb begin
    ptr_o = '0;
    ok_o  = 1'b0;
    for (int k = 0; k < NPAIR; k++) begin
      if (int'(sel_i) == k) begin
        ptr_o = pair[k];
        ok_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dag_ea_calc.sv
module dag_ea_calc
  import dag_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          RIDX_W  = 5,
  parameter int          IO_W    = 6,
  parameter int          DISP_W  = 6,
  parameter logic [15:0] IO_BASE = 16'h0020
) (
  input  amode_e          mode_i,
  input  logic [RIDX_W-1:0] reg_idx_i,
  input  logic [IO_W-1:0]   io_addr_i,
  input  logic [AW-1:0]     word2_i,
  input  logic [1:0]        sel_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [AW-1:0]     ptr_i,
  input  logic              ptr_ok_i,
  output logic [AW-1:0]     ea_o,
  output logic [1:0]        cycles_o,
  output logic              wb_en_o,
  output logic [1:0]        wb_ptr_o,
  output logic [AW-1:0]     wb_val_o,
  output logic              err_o
);
  localparam logic [1:0] CYC_ONE = 2'd1;
  localparam logic [1:0] CYC_TWO = 2'd2;

  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [AW-1:0] io_map(input logic [IO_W-1:0] a);
    return wrap_add(AW'(a), AW'(IO_BASE));
  endfunction

  logic disp_base_ok;
  assign disp_base_ok = ptr_ok_i && (sel_i != PP_X);

  always_comb begin
    ea_o     = '0;
    cycles_o = '0;
    wb_en_o  = 1'b0;
    wb_ptr_o = '0;
    wb_val_o = '0;
    err_o    = 1'b0;
    unique case (mode_i)
      AM_IMM:  cycles_o = CYC_ONE;
      AM_REG: begin ea_o = AW'(reg_idx_i); cycles_o = CYC_TWO; end
      AM_IO:  begin ea_o = io_map(io_addr_i); cycles_o = CYC_ONE; end
      AM_DIR: begin ea_o = word2_i; cycles_o = CYC_TWO; end
      AM_IND: begin
        if (ptr_ok_i) begin ea_o = ptr_i; cycles_o = CYC_TWO; end
        else err_o = 1'b1;
      end
      AM_DISP: begin
        if (disp_base_ok) begin
          ea_o = wrap_add(ptr_i, AW'(disp_i));
          cycles_o = CYC_TWO;
        end else err_o = 1'b1;
      end
      AM_PINC: begin
        if (ptr_ok_i) begin
          ea_o     = ptr_i;
          wb_val_o = wrap_add(ptr_i, AW'(1));
          wb_en_o  = 1'b1;
          wb_ptr_o = sel_i;
          cycles_o = CYC_TWO;
        end else err_o = 1'b1;
      end
      AM_PDEC: begin
        if (ptr_ok_i) begin
          ea_o     = wrap_add(ptr_i, '1);
          wb_val_o = wrap_add(ptr_i, '1);
          wb_en_o  = 1'b1;
          wb_ptr_o = sel_i;
          cycles_o = CYC_TWO;
        end else err_o = 1'b1;
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dag_top.sv
module dag_top
  import dag_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          RIDX_W  = 5,
  parameter int          IO_W    = 6,
  parameter int          DISP_W  = 6,
  parameter int          NPAIR   = 3,
  parameter logic [15:0] IO_BASE = 16'h0020
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [2:0]          mode,
  input  logic [RIDX_W-1:0]   reg_idx,
  input  logic [IO_W-1:0]     io_addr,
  input  logic [AW-1:0]       word2,
  input  logic [1:0]          ptr_sel,
  input  logic [DISP_W-1:0]   disp,
  input  logic [NPAIR*AW-1:0] ptr_regs,
  output logic                res_valid,
  output logic [AW-1:0]       ea,
  output logic [1:0]          cycles,
  output logic                wb_en,
  output logic [1:0]          wb_ptr,
  output logic [AW-1:0]       wb_val,
  output logic                mode_err
);
  localparam logic [AW-1:0] IO_LO = AW'(IO_BASE);
  localparam logic [AW-1:0] IO_HI = AW'(IO_BASE) + AW'((1 << IO_W) - 1);

  logic [AW-1:0] sel_ptr;
  logic          sel_ok;
  logic [AW-1:0] c_ea, c_wb_val;
  logic [1:0]    c_cycles, c_wb_ptr;
  logic          c_wb_en, c_err;
  amode_e        q_mode;

  dag_ptr_mux #(.AW(AW), .NPAIR(NPAIR)) u_mux (
    .regs_i(ptr_regs), .sel_i(ptr_sel), .ptr_o(sel_ptr), .ok_o(sel_ok)
  );

  dag_ea_calc #(.AW(AW), .RIDX_W(RIDX_W), .IO_W(IO_W), .DISP_W(DISP_W), .IO_BASE(IO_BASE)) u_calc (
    .mode_i(amode_e'(mode)), .reg_idx_i(reg_idx), .io_addr_i(io_addr), .word2_i(word2),
    .sel_i(ptr_sel), .disp_i(disp), .ptr_i(sel_ptr), .ptr_ok_i(sel_ok),
    .ea_o(c_ea), .cycles_o(c_cycles), .wb_en_o(c_wb_en), .wb_ptr_o(c_wb_ptr),
    .wb_val_o(c_wb_val), .err_o(c_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0; ea <= '0; cycles <= '0; wb_en <= 1'b0;
      wb_ptr <= '0; wb_val <= '0; mode_err <= 1'b0; q_mode <= AM_IMM;
    end else if (req_valid) begin
      res_valid <= 1'b1; ea <= c_ea; cycles <= c_cycles; wb_en <= c_wb_en;
      wb_ptr <= c_wb_ptr; wb_val <= c_wb_val; mode_err <= c_err; q_mode <= amode_e'(mode);
    end else begin
      res_valid <= 1'b0; ea <= '0; cycles <= '0; wb_en <= 1'b0;
      wb_ptr <= '0; wb_val <= '0; mode_err <= 1'b0; q_mode <= AM_IMM;
    end
  end

  // R10
  wb_only_autoidx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (res_valid && !mode_err && (q_mode == AM_PINC || q_mode == AM_PDEC)));

  // R8
  postinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && q_mode == AM_PINC) |-> (wb_val == ea + AW'(1)));

  // R9
  predec_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && q_mode == AM_PDEC) |-> (wb_val == ea));

  // R4
  io_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && q_mode == AM_IO) |-> (ea >= IO_LO && ea <= IO_HI && cycles == 2'd1));

  // R12
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (!wb_en && ea == '0 && cycles == 2'd0));

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> (!res_valid && !wb_en && ea == '0));
endmodule

// File: tb/dag_top_tb.sv
module dag_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [4:0]  reg_idx = '0;
  logic [5:0]  io_addr = '0;
  logic [15:0] word2 = '0;
  logic [1:0]  ptr_sel = '0;
  logic [5:0]  disp = '0;
  logic [47:0] ptr_regs = '0;
  logic        res_valid, wb_en, mode_err;
  logic [15:0] ea, wb_val;
  logic [1:0]  cycles, wb_ptr;

  int vectors = 0;
  int fails = 0;

  // expected outputs for the next sample
  int e_valid = 0, e_ea = 0, e_cyc = 0, e_wben = 0, e_wbp = 0, e_wbv = 0, e_err = 0;
  string e_tag = "R1";

  always #4 clk = ~clk;

  dag_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .reg_idx(reg_idx),
    .io_addr(io_addr), .word2(word2), .ptr_sel(ptr_sel), .disp(disp), .ptr_regs(ptr_regs),
    .res_valid(res_valid), .ea(ea), .cycles(cycles), .wb_en(wb_en), .wb_ptr(wb_ptr),
    .wb_val(wb_val), .mode_err(mode_err)
  );

  function automatic int pair_val(int s);
    int lo, hi;
    lo = int'(ptr_regs[16*s +: 8]);
    hi = int'(ptr_regs[16*s+8 +: 8]);
    return hi * 256 + lo;
  endfunction

  task automatic set_idle_expect(string tag);
    e_valid = 0; e_ea = 0; e_cyc = 0; e_wben = 0; e_wbp = 0; e_wbv = 0; e_err = 0; e_tag = tag;
  endtask

  task automatic model(string tag);
    int p, m, s;
    m = int'(mode); s = int'(ptr_sel);
    set_idle_expect(tag);
    e_valid = 1;
    p = (s < 3) ? pair_val(s) : 0;
    case (m)
      0: e_cyc = 1;
      1: begin e_ea = int'(reg_idx); e_cyc = 2; end
      2: begin e_ea = int'(io_addr) + 32; e_cyc = 1; end
      3: begin e_ea = int'(word2); e_cyc = 2; end
      4: if (s == 3) e_err = 1; else begin e_ea = p; e_cyc = 2; end
      5: if (s == 3 || s == 0) e_err = 1;
         else begin e_ea = (p + int'(disp)) % 65536; e_cyc = 2; end
      6: if (s == 3) e_err = 1;
         else begin e_ea = p; e_wbv = (p + 1) % 65536; e_wben = 1; e_wbp = s; e_cyc = 2; end
      default: if (s == 3) e_err = 1;
         else begin e_ea = (p + 65535) % 65536; e_wbv = e_ea; e_wben = 1; e_wbp = s; e_cyc = 2; end
    endcase
  endtask

  task automatic compare();
    vectors++;
    if (int'(res_valid) != e_valid || int'(ea) != e_ea || int'(cycles) != e_cyc ||
        int'(wb_en) != e_wben || int'(wb_ptr) != e_wbp || int'(wb_val) != e_wbv ||
        int'(mode_err) != e_err) begin
      fails++;
      $display("FAIL %s: got v=%0d ea=%h cyc=%0d wb=%0d/%0d/%h err=%0d exp v=%0d ea=%h cyc=%0d wb=%0d/%0d/%h err=%0d",
        e_tag, res_valid, ea, cycles, wb_en, wb_ptr, wb_val, mode_err,
        e_valid, e_ea[15:0], e_cyc, e_wben, e_wbp, e_wbv[15:0], e_err);
    end
  endtask

  // one clock per call: compare pending expectation, drive next request
  task automatic step(bit v, int m, int ri, int io, int w2, int sel, int d, string tag);
    @(negedge clk);
    compare();
    req_valid = v; mode = 3'(m); reg_idx = 5'(ri); io_addr = 6'(io);
    word2 = 16'(w2); ptr_sel = 2'(sel); disp = 6'(d);
    if (v) model(tag); else set_idle_expect(tag);
  endtask

  task automatic set_ptrs(int x, int y, int z);
    @(negedge clk);
    compare();
    ptr_regs = {16'(z), 16'(y), 16'(x)};
    req_valid = 1'b0;
    set_idle_expect("R2");
  endtask

  initial begin : watchdog
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    // R1: outputs zero during reset
    repeat (2) @(negedge clk);
    set_idle_expect("R1");
    compare();
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    set_ptrs(16'h1234, 16'hFFF0, 16'h0000);
    step(1, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 1, 0, 0, 0, 0, 0, "R3");
    step(1, 1, 31, 0, 0, 0, 0, "R3");
    step(1, 2, 0, 0, 0, 0, 0, "R4");
    step(1, 2, 0, 63, 0, 0, 0, "R4");
    step(1, 3, 0, 0, 16'hFFFF, 0, 0, "R5");
    step(1, 3, 0, 0, 16'h0000, 0, 0, "R5");
    step(0, 3, 0, 0, 16'h5555, 0, 0, "R2");
    step(1, 4, 0, 0, 0, 0, 0, "R6");
    step(1, 4, 0, 0, 0, 1, 0, "R6");
    step(1, 4, 0, 0, 0, 2, 0, "R6");
    step(1, 4, 0, 0, 0, 3, 0, "R12");
    step(1, 5, 0, 0, 0, 1, 63, "R7");
    step(1, 5, 0, 0, 0, 2, 0, "R7");
    step(1, 5, 0, 0, 0, 0, 5, "R12");
    step(1, 7, 0, 0, 0, 2, 0, "R9");
    step(1, 6, 0, 0, 0, 0, 0, "R8");
    step(1, 6, 0, 0, 0, 3, 0, "R12");
    set_ptrs(16'hFFFF, 16'h8000, 16'h00FF);
    step(1, 6, 0, 0, 0, 0, 0, "R8");
    step(1, 7, 0, 0, 0, 1, 0, "R9");
    step(1, 5, 0, 0, 0, 2, 1, "R7");
    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0) set_ptrs($urandom, $urandom, $urandom);
      step(($urandom % 4) != 0, $urandom % 8, $urandom % 32, $urandom % 64,
           $urandom % 65536, $urandom % 4, $urandom % 64, "R10");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R2");
    @(negedge clk);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule